// File: doc/BRIEF.md
# Partial Word and Doubleword Merge Unit

This block carries out the left and right partial loads and stores of a 64-bit core. These instructions move part of a word or doubleword that crosses an alignment boundary. The core gives it an operation code, a byte address and the current value of the target register. The unit then performs one aligned read on a 64-bit memory port. A load merges the memory bytes into the register value and returns it for writeback. A store merges the register bytes into the memory value and writes the doubleword back to the same aligned address.

Byte order is little-endian. The memory port always carries a full aligned doubleword. Word operations work on the 32-bit lane that address bit 2 selects. None of these operations raises an alignment fault: the low address bits only select which bytes are merged. The read is always issued, even when the target register is the hardwired zero register. In that case the register write is suppressed.

Top module: `ldst_merge_unit`

## Requirements
- R1: The memory address is the input address with bits [1:0] cleared for word operations and bits [2:0] cleared for doubleword operations. No fault is signalled for any offset. The operation code is `op[2]` = store, `op[1]` = doubleword, `op[0]` = right variant.
- R2: Word-left load, with k = addr[1:0] and M the memory word in the lane addr[2] selects: result byte i (0..3) is M byte (i-3+k) when i >= 3-k, otherwise rt byte i. The 32-bit result is sign-extended to 64 bits.
- R3: Word-right load: result byte i is M byte (i+k) when i <= 3-k, otherwise rt byte i. For k = 0 the word is sign-extended to 64 bits. For k > 0 the upper 32 bits of rt are kept.
- R4: Doubleword loads use k = addr[2:0] and the same byte rules with 7 in place of 3. There is no sign extension.
- R5: Word-left store: written word byte i is rt byte (i+3-k) when i <= k, otherwise M byte i. The other 32-bit lane of the doubleword is rewritten unchanged.
- R6: Word-right store: written word byte i is rt byte (i-k) when i >= k, otherwise M byte i. The other lane is unchanged.
- R7: Doubleword stores follow R5 and R6 over 8 bytes with k = addr[2:0].
- R8: A store issues exactly one read and then exactly one write, both at the same aligned address. The write comes two cycles after the read.
- R9: A load issues exactly one read and no write. `rf_we` is high only in the done cycle of a load whose `rt_zero` was low. The read still happens when `rt_zero` is high.
- R10: `done` is a one-cycle pulse. A load completes 3 cycles and a store 4 cycles after the edge that accepts `start`. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new operation when idle |
| op | input | 3 | {store, doubleword, right} |
| addr | input | AW | Effective byte address |
| rt_val | input | 64 | Current target register value |
| rt_zero | input | 1 | Target is the zero register; suppress writeback |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_we | output | 1 | Register writeback enable (loads only) |
| rf_wdata | output | 64 | Merged register value |
| mem_addr | output | AW | Aligned memory address |
| mem_rd | output | 1 | Read request; data returns one cycle later |
| mem_rdata | input | 64 | Read data |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 64 | Write data |

## Verification
The bench drives `start` on a falling edge. It then counts falling edges until `done` is seen and expects exactly 3 for loads and 4 for stores. Register results are read in that done cycle. Memory contents are compared at the same point, since the store write lands on the edge just before it. Read and write requests are tallied on each falling edge in between, and the address is compared while the read is high. The cycle after `done` is checked to confirm the pulse has dropped. In the injection case, two further cycles are checked to confirm that no second read starts.

// File: rtl/ldst_merge_unit.sv
module ldst_merge_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [63:0]   rt_val,
  input  logic          rt_zero,
  output logic          busy,
  output logic          done,
  output logic          rf_we,
  output logic [63:0]   rf_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [63:0]   mem_rdata,
  output logic          mem_wr,
  output logic [63:0]   mem_wdata
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CAPT, S_WRITE, S_DONE} st_t;
  st_t st;

  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [63:0]   rt_q, res_q, merged;
  logic          rz_q;

  wire is_st = op_q[2];
  wire is_dw = op_q[1];
  wire is_rt = op_q[0];

  wire [5:0] w_lsh = 6'd24 - {1'b0, addr_q[1:0], 3'b000};
  wire [5:0] w_rsh = {1'b0, addr_q[1:0], 3'b000};
  wire [5:0] d_lsh = 6'd56 - {addr_q[2:0], 3'b000};
  wire [5:0] d_rsh = {addr_q[2:0], 3'b000};

  wire [31:0] ones32 = 32'hFFFF_FFFF;
  wire [63:0] ones64 = 64'hFFFF_FFFF_FFFF_FFFF;
  wire [31:0] mw = addr_q[2] ? mem_rdata[63:32] : mem_rdata[31:0];
  wire [31:0] rw = rt_q[31:0];

  wire [31:0] wl_ld = (mw << w_lsh) | (rw & ~(ones32 << w_lsh));
  wire [31:0] wr_ld = (mw >> w_rsh) | (rw & ~(ones32 >> w_rsh));
  wire [63:0] dl_ld = (mem_rdata << d_lsh) | (rt_q & ~(ones64 << d_lsh));
  wire [63:0] dr_ld = (mem_rdata >> d_rsh) | (rt_q & ~(ones64 >> d_rsh));
  wire [31:0] wl_st = (rw >> w_lsh) | (mw & ~(ones32 >> w_lsh));
  wire [31:0] wr_st = (rw << w_rsh) | (mw & ~(ones32 << w_rsh));
  wire [63:0] dl_st = (rt_q >> d_lsh) | (mem_rdata & ~(ones64 >> d_lsh));
  wire [63:0] dr_st = (rt_q << d_rsh) | (mem_rdata & ~(ones64 << d_rsh));

  wire [31:0] w_st = is_rt ? wr_st : wl_st;
  wire [63:0] w_st64 = addr_q[2] ? {w_st, mem_rdata[31:0]} : {mem_rdata[63:32], w_st};

  always_comb begin
    unique case ({is_st, is_dw, is_rt})
      3'b000: merged = {{32{wl_ld[31]}}, wl_ld};
      3'b001: merged = (addr_q[1:0] == 2'd0) ? {{32{wr_ld[31]}}, wr_ld} : {rt_q[63:32], wr_ld};
      3'b010: merged = dl_ld;
      3'b011: merged = dr_ld;
      3'b110: merged = dl_st;
      3'b111: merged = dr_st;
      default: merged = w_st64;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      rt_q   <= '0;
      rz_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= addr;
          rt_q   <= rt_val;
          rz_q   <= rt_zero;
          st     <= S_READ;
        end
        S_READ:  st <= S_CAPT;
        S_CAPT: begin
          res_q <= merged;
          st    <= is_st ? S_WRITE : S_DONE;
        end
        S_WRITE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = is_dw ? {addr_q[AW-1:3], 3'b000} : {addr_q[AW-1:2], 2'b00};
  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_WRITE);
  assign mem_wdata = res_q;
  assign rf_wdata  = res_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign rf_we     = done && !is_st && !rz_q;

endmodule

// File: rtl/ldst_merge_unit_chk.sv
module ldst_merge_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          rf_we,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    op_q
);

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00 && (!op_q[1] || !mem_addr[2])));

  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  a_r8_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $stable(mem_addr));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r9_we_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q[2]) |-> $past(mem_rd, 2));

endmodule

bind ldst_merge_unit ldst_merge_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rf_we(rf_we),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .op_q(op_q)
);

// File: tb/test_ldst_merge_unit.sv
`timescale 1ns/1ps
module test_ldst_merge_unit;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rt_zero = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [63:0] rt_val = '0, mem_rdata = '0;
  logic busy, done, rf_we, mem_rd, mem_wr;
  logic [63:0] rf_wdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  logic [63:0] memm [16];
  logic [63:0] shadow [16];

  always #2.5 clk = ~clk;

  ldst_merge_unit #(.AW(AW)) i_ldst_merge_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .rt_val(rt_val), .rt_zero(rt_zero), .busy(busy), .done(done),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= memm[mem_addr[6:3]];
    if (mem_wr) memm[mem_addr[6:3]] <= mem_wdata;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010, 3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] ref_op(input logic [2:0] o, input logic [31:0] a,
                                          input logic [63:0] r, input logic [63:0] m);
    logic [63:0] mv, rv, v;
    int k, n, j;
    if (o[1]) begin k = int'(a[2:0]); n = 7; mv = m; rv = r; end
    else begin
      k = int'(a[1:0]); n = 3; rv = {32'd0, r[31:0]};
      mv = {32'd0, (a[2] ? m[63:32] : m[31:0])};
    end
    v = '0;
    for (int i = 0; i <= n; i++) begin
      case ({o[2], o[0]})
        2'b00: begin j = i - (n - k); v[8*i +: 8] = (i >= n - k) ? mv[8*j +: 8] : rv[8*i +: 8]; end
        2'b01: begin j = i + k;       v[8*i +: 8] = (i <= n - k) ? mv[8*j +: 8] : rv[8*i +: 8]; end
        2'b10: begin j = i + n - k;   v[8*i +: 8] = (i <= k) ? rv[8*j +: 8] : mv[8*i +: 8]; end
        default: begin j = i - k;     v[8*i +: 8] = (i >= k) ? rv[8*j +: 8] : mv[8*i +: 8]; end
      endcase
    end
    if (o[1]) return v;
    if (o[2]) return a[2] ? {v[31:0], m[31:0]} : {m[63:32], v[31:0]};
    if (o[0] && k != 0) return {r[63:32], v[31:0]};
    return {{32{v[31]}}, v[31:0]};
  endfunction

  task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [63:0] r,
                       input logic z, input logic inject);
    int idx, cyc, reads, writes, lat;
    logic [63:0] exp;
    logic [31:0] al;
    idx = int'(a[6:3]);
    exp = ref_op(o, a, r, shadow[idx]);
    al  = o[1] ? {a[31:3], 3'b000} : {a[31:2], 2'b00};
    lat = o[2] ? 4 : 3;
    @(negedge clk);
    start = 1'b1; op = o; addr = a; rt_val = r; rt_zero = z;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; reads = 0; writes = 0;
    while (!done && cyc < 20) begin
      if (mem_rd) begin
        reads++;
        chk(mem_addr == al, "R1 aligned address", 64'(mem_addr), 64'(al));
      end
      if (mem_wr) begin
        writes++;
        chk(mem_addr == al, "R8 write address", 64'(mem_addr), 64'(al));
      end
      if (inject && cyc == 1) begin start = 1'b1; op = 3'b100; addr = 32'h8; rt_val = '1; end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(cyc == lat, "R10 latency", 64'(cyc), 64'(lat));
    chk(reads == 1, o[2] ? "R8 read count" : "R9 read count", 64'(reads), 64'd1);
    chk(writes == int'(o[2]), o[2] ? "R8 write count" : "R9 write count", 64'(writes), 64'(o[2]));
    if (o[2]) begin
      chk(rf_we == 1'b0, "R9 no writeback on store", 64'(rf_we), 64'd0);
      chk(memm[idx] == exp, tag(o), memm[idx], exp);
      shadow[idx] = exp;
    end else begin
      chk(rf_we == !z, "R9 writeback enable", 64'(rf_we), 64'(!z));
      if (!z) chk(rf_wdata == exp, tag(o), rf_wdata, exp);
      chk(memm[idx] == shadow[idx], "R9 load leaves memory", memm[idx], shadow[idx]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done pulse", 64'(done), 64'd0);
    if (inject) begin
      for (int t = 0; t < 2; t++) begin
        chk(!busy && !mem_rd, "R10 start ignored while busy", 64'({busy, mem_rd}), 64'd0);
        @(negedge clk);
      end
      chk(memm[1] == shadow[1], "R10 injected store absent", memm[1], shadow[1]);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      memm[i] = {$urandom, $urandom};
      shadow[i] = memm[i];
    end
    repeat (3) @(negedge clk);
    chk({busy, done, rf_we, mem_rd, mem_wr} == 5'b0, "R10 reset state",
        64'({busy, done, rf_we, mem_rd, mem_wr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: every op at smallest and largest offset, both word lanes
    for (int o = 0; o < 8; o++) begin
      do_op(3'(o), 32'h0000_0010, 64'h8899_AABB_CCDD_EEFF, 1'b0, 1'b0);
      do_op(3'(o), 32'h0000_001F, 64'hF1E2_D3C4_B5A6_9788, 1'b0, 1'b0);
      do_op(3'(o), 32'h0000_0025, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
    end
    // R3 sign extension at k=0 with negative word, R9 zero register
    shadow[2] = 64'h1111_1111_8000_0001; memm[2] = shadow[2];
    do_op(3'b001, 32'h0000_0010, 64'hDEAD_BEEF_0000_0000, 1'b0, 1'b0);
    do_op(3'b000, 32'h0000_0013, 64'h0, 1'b1, 1'b0);
    // R10 start pulse while busy
    do_op(3'b110, 32'h0000_0033, 64'hCAFE_F00D_1234_5678, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++)
      do_op(3'($urandom), {25'd0, 7'($urandom)}, {$urandom, $urandom}, ($urandom % 8) == 0, 1'b0);
    summary();
  end
endmodule